// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block gathers nineteen maskable interrupt factor flags and one unmaskable watchdog flag into eight vector groups. A single-cycle pulse from a peripheral sets each flag. Software clears a flag by writing 1 to its bit. Each maskable flag has its own enable bit. A group is pending when any of its enabled flags is set, and the watchdog group is pending whenever the watchdog flag is set. The controller keeps the CPU interrupt-enable flag itself. It raises one request line to the CPU and presents the vector of the highest-priority pending group. The vectors lie on the page 0100H, two addresses apart.

When the CPU signals that an instruction has retired while the request is high, a four-step entry sequencer takes over. It saves the CPU flag register, clears the interrupt-enable flag, pushes the return PC into a stack in RAM, and loads the vector into the PC. The sequencer then acknowledges and no further request is raised until software sets the enable flag again. The stack push is the only data stream leaving the block, and it uses valid/ready. `push_valid` stays high with `push_data` stable until `push_ready` is seen high on a clock edge. The stack may stall the push for any number of cycles.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle high on `src_pulse[i]` sets maskable flag i, and a high on `wdt_pulse` sets the watchdog flag. A set flag holds until it is cleared.
- R2: A write to address 0 clears each flag whose `reg_wdata` bit is 1. A write to address 2 with bit 0 set clears the watchdog flag. When a set and a clear fall in the same cycle, the set wins.
- R3: All mask bits and flags reset to 0. A write to address 1 loads the masks. Reads are combinational: address 0 returns the flags, address 1 the masks, address 2 the watchdog flag in bit 0, and address 3 returns 0.
- R4: The flag bits map to groups as follows: bits 0–2 to group 1 (dialer/FSK), bits 3–4 to group 2 (programmable timer), bits 5–10 to group 3 (serial), bit 11 to group 4 (first key port), bit 12 to group 5 (second key port), bits 13–16 to group 6 (clock timer) and bits 17–18 to group 7 (stopwatch). A group is pending when any of its flag AND mask terms is 1.
- R5: Group 0, the watchdog, is pending whenever the watchdog flag is set. No mask bit affects it.
- R6: `irq_req` is high exactly when the interrupt-enable flag is 1, some group is pending and the sequencer is idle.
- R7: When several groups are pending, the lowest group number wins.
- R8: `irq_vector` equals 0100H plus twice the winning group number, so only bits 3..1 vary.
- R9: Entry starts only on a cycle where `instr_done` and `irq_req` are both high. Without `instr_done` the sequencer stays idle.
- R10: After acceptance, the next cycle drives `save_valid` with the flags presented at acceptance. The enable flag is 0 from the cycle after that, which also begins the push of the PC presented at acceptance. The cycle after the push handshake drives `pc_load_valid` with the vector captured at acceptance, together with `entry_ack`.
- R11: While `push_valid` is high and `push_ready` is low, `push_valid` and `push_data` stay unchanged.
- R12: A pulse on `ei_set` sets the interrupt-enable flag, which resets to 0. While it is 0 no request is raised, even with groups pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 19 | Set pulses for the maskable flags |
| wdt_pulse | input | 1 | Set pulse for the watchdog flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 19 | Register write data |
| reg_rdata | output | 19 | Register read data |
| ei_set | input | 1 | Sets the interrupt-enable flag |
| i_flag | output | 1 | Interrupt-enable flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 16 | Vector of the winning group |
| instr_done | input | 1 | Current instruction has retired |
| cur_pc | input | 16 | Return PC presented with instr_done |
| cur_flags | input | 4 | CPU flag register presented with instr_done |
| save_valid | output | 1 | Flag-register save step |
| save_data | output | 4 | Saved flag register value |
| push_valid | output | 1 | Stack push valid |
| push_ready | input | 1 | Stack push ready |
| push_data | output | 16 | Return PC to push |
| pc_load_valid | output | 1 | Load vector into PC |
| pc_load_addr | output | 16 | Vector to load |
| entry_ack | output | 1 | Final entry step acknowledge |

## Verification
A flag or mask bit stuck at the wrong value shows up on `reg_rdata` the first cycle that register is addressed. It also reaches `irq_req` and `irq_vector` in the same cycle, because both are combinational from the stored state. A wrong priority order or group map gives a wrong vector as soon as two groups are pending together. A sequencer that skips or reorders a step shows on the save, push or load strobe within one cycle of the expected step. A failure to clear the enable flag leaves `irq_req` high after `entry_ack` while flags are still pending.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NF       = 19;
  localparam int NG       = 8;
  localparam int GW       = $clog2(NG);
  localparam int PC_W     = 16;
  localparam int CF_W     = 4;
  localparam logic [PC_W-1:0] VEC_BASE = 16'h0100;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_PUSH, ST_LOAD} ent_st_e;

  // group number (1..7) of maskable flag bit b; the ordering is decoded by the encoder
  function automatic int flag_group(input int b);
    if (b < 3)       return 1;
    else if (b < 5)  return 2;
    else if (b < 11) return 3;
    else if (b < 12) return 4;
    else if (b < 13) return 5;
    else if (b < 17) return 6;
    else             return 7;
  endfunction

  function automatic logic [NF-1:0] group_bits(input int g);
    logic [NF-1:0] v;
    v = '0;
    for (int b = 0; b < NF; b++) if (flag_group(b) == g) v[b] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import prio_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] src_pulse,
  input  logic          wdt_pulse,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [NF-1:0] reg_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] masks,
  output logic          wdt_flag,
  output logic [NF-1:0] reg_rdata
);
  logic wr_flag, wr_mask, wr_wdt;
  assign wr_flag = reg_wr && (reg_addr == 2'd0);
  assign wr_mask = reg_wr && (reg_addr == 2'd1);
  assign wr_wdt  = reg_wr && (reg_addr == 2'd2);

  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flags[i] <= 1'b0;
      else if (src_pulse[i])               flags[i] <= 1'b1;
      else if (wr_flag && reg_wdata[i])    flags[i] <= 1'b0;
    end

    // R1
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_pulse[i] |=> flags[i]);
    // R2
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && reg_wdata[i] && !src_pulse[i]) |=> !flags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       masks <= '0;
    else if (wr_mask) masks <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wdt_flag <= 1'b0;
    else if (wdt_pulse)              wdt_flag <= 1'b1;
    else if (wr_wdt && reg_wdata[0]) wdt_flag <= 1'b0;
  end

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = flags;
      2'd1:    reg_rdata = masks;
      2'd2:    reg_rdata = {{(NF-1){1'b0}}, wdt_flag};
      default: reg_rdata = '0;
    endcase
  end

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(masks));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   flags,
  input  logic [NF-1:0]   masks,
  input  logic            wdt_flag,
  output logic            any_pend,
  output logic [PC_W-1:0] vector
);
  logic [NF-1:0] live;
  logic [NG-1:0] grp_pend;
  logic [NG-1:0] grant;
  logic [GW-1:0] win;

  assign live        = flags & masks;
  assign grp_pend[0] = wdt_flag;

  for (genvar g = 1; g < NG; g++) begin : g_grp
    localparam logic [NF-1:0] SEL = group_bits(g);
    assign grp_pend[g] = |(live & SEL);
  end

  always_comb begin
    win   = '0;
    grant = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_pend[g]) begin
        win   = GW'(g);
        grant = NG'(1) << g;
      end
    end
  end

  assign any_pend = |grp_pend;
  assign vector   = VEC_BASE | (PC_W'(win) << 1);

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant == '0) == !any_pend));
  // R5
  wdt_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_flag |-> (vector == VEC_BASE));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_pend,
  input  logic [PC_W-1:0] vector,
  input  logic            ei_set,
  input  logic            instr_done,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [CF_W-1:0] cur_flags,
  output logic            i_flag,
  output logic            irq_req,
  output logic            save_valid,
  output logic [CF_W-1:0] save_data,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [PC_W-1:0] push_data,
  output logic            pc_load_valid,
  output logic [PC_W-1:0] pc_load_addr,
  output logic            entry_ack
);
  ent_st_e         st;
  logic            accept;
  logic [PC_W-1:0] pc_q, vec_q;
  logic [CF_W-1:0] cf_q;

  assign irq_req = i_flag && any_pend && (st == ST_IDLE);
  assign accept  = irq_req && instr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      pc_q  <= '0;
      vec_q <= '0;
      cf_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st    <= ST_SAVE;
          pc_q  <= cur_pc;
          vec_q <= vector;
          cf_q  <= cur_flags;
        end
        ST_SAVE: st <= ST_PUSH;
        ST_PUSH: if (push_ready) st <= ST_LOAD;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              i_flag <= 1'b0;
    else if (st == ST_SAVE)  i_flag <= 1'b0;
    else if (ei_set)         i_flag <= 1'b1;
  end

  assign save_valid    = (st == ST_SAVE);
  assign save_data     = cf_q;
  assign push_valid    = (st == ST_PUSH);
  assign push_data     = pc_q;
  assign pc_load_valid = (st == ST_LOAD);
  assign pc_load_addr  = vec_q;
  assign entry_ack     = (st == ST_LOAD);

  // R11
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));
  // R10
  save_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |=> (push_valid && !i_flag));
  // R10
  load_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (pc_load_valid && entry_ack));
  // R12
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> i_flag);
  // R9
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_valid) |-> $past(instr_done && irq_req));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   src_pulse,
  input  logic            wdt_pulse,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NF-1:0]   reg_wdata,
  output logic [NF-1:0]   reg_rdata,
  input  logic            ei_set,
  output logic            i_flag,
  output logic            irq_req,
  output logic [PC_W-1:0] irq_vector,
  input  logic            instr_done,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [CF_W-1:0] cur_flags,
  output logic            save_valid,
  output logic [CF_W-1:0] save_data,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [PC_W-1:0] push_data,
  output logic            pc_load_valid,
  output logic [PC_W-1:0] pc_load_addr,
  output logic            entry_ack
);
  logic [NF-1:0] flags, masks;
  logic          wdt_flag, any_pend;

  irq_flag_bank u_bank (
    .clk, .rst_n, .src_pulse, .wdt_pulse, .reg_wr, .reg_addr, .reg_wdata,
    .flags, .masks, .wdt_flag, .reg_rdata
  );

  irq_prio_enc u_enc (
    .clk, .rst_n, .flags, .masks, .wdt_flag, .any_pend, .vector(irq_vector)
  );

  irq_entry_seq u_seq (
    .clk, .rst_n, .any_pend, .vector(irq_vector), .ei_set, .instr_done,
    .cur_pc, .cur_flags, .i_flag, .irq_req, .save_valid, .save_data,
    .push_valid, .push_ready, .push_data, .pc_load_valid, .pc_load_addr,
    .entry_ack
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NF = 19;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NF-1:0] src_pulse = '0, reg_wdata = '0, reg_rdata;
  logic wdt_pulse = 0, reg_wr = 0, ei_set = 0, instr_done = 0, push_ready = 0;
  logic [1:0] reg_addr = '0;
  logic [15:0] cur_pc = '0, irq_vector, push_data, pc_load_addr;
  logic [3:0] cur_flags = '0, save_data;
  logic i_flag, irq_req, save_valid, push_valid, pc_load_valid, entry_ack;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  int checks = 0, errors = 0;
  logic [NF-1:0] mf = '0, mm = '0;
  logic mw = 0, mi = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] groups(input logic [NF-1:0] f, input logic [NF-1:0] m, input logic w);
    logic [NF-1:0] l;
    l = f & m;
    return {|l[18:17], |l[16:13], l[12], l[11], |l[10:5], |l[4:3], |l[2:0], w};
  endfunction

  function automatic logic [15:0] exp_vec(input logic [7:0] g);
    for (int k = 0; k < 8; k++) if (g[k]) return 16'h0100 + 16'(2 * k);
    return 16'h0100;
  endfunction

  task automatic idle_in();
    src_pulse = '0; wdt_pulse = 0; reg_wr = 0; ei_set = 0; instr_done = 0;
  endtask

  // one random cycle: drive at negedge, check combinational outputs, update model
  task automatic rnd_cycle();
    logic [7:0] g;
    int a;
    @(negedge clk);
    idle_in();
    src_pulse = ($urandom % 4 == 0) ? NF'($urandom) & NF'($urandom) : '0;
    wdt_pulse = ($urandom % 16 == 0);
    a = $urandom % 4;
    reg_addr = 2'(a);
    reg_wr = ($urandom % 3 == 0);
    reg_wdata = NF'($urandom);
    #1;
    case (a)
      0: chk("R3 rd flags", 32'(reg_rdata), 32'(mf));
      1: chk("R3 rd masks", 32'(reg_rdata), 32'(mm));
      2: chk("R3 rd wdt", 32'(reg_rdata), 32'(mw));
      default: chk("R3 rd unused", 32'(reg_rdata), 0);
    endcase
    g = groups(mf, mm, mw);
    chk("R6 R12 req", 32'(irq_req), 32'(mi && (g != 0)));
    if (g != 0) chk("R4 R5 R7 R8 vector", 32'(irq_vector), 32'(exp_vec(g)));
    if (reg_wr && a == 0) mf = mf & ~reg_wdata;
    if (reg_wr && a == 2 && reg_wdata[0]) mw = 0;
    if (reg_wr && a == 1) mm = reg_wdata;
    mf = mf | src_pulse;
    if (wdt_pulse) mw = 1;
  endtask

  task automatic clear_all();
    @(negedge clk); idle_in(); reg_wr = 1; reg_addr = 0; reg_wdata = '1;
    @(negedge clk); reg_addr = 2; reg_wdata = '1;
    @(negedge clk); reg_wr = 0; mf = '0; mw = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    reg_addr = 1; #1;
    chk("R3 mask reset", 32'(reg_rdata), 0);
    reg_addr = 0; #1;
    chk("R3 flag reset", 32'(reg_rdata), 0);
    chk("R12 I reset", 32'(i_flag), 0);

    // directed: set and clear in the same cycle, set wins
    @(negedge clk); src_pulse = 19'h00010; reg_wr = 1; reg_addr = 0; reg_wdata = 19'h00010;
    @(negedge clk); idle_in(); reg_addr = 0; #1;
    chk("R2 set wins", 32'(reg_rdata), 32'h10);
    chk("R1 flag held", 32'(reg_rdata[4]), 1);
    @(negedge clk); reg_wr = 1; reg_wdata = 19'h00010;
    @(negedge clk); reg_wr = 0; #1;
    chk("R2 w1c clear", 32'(reg_rdata), 0);

    // random with I clear
    for (int n = 0; n < 400; n++) rnd_cycle();
    // set I and continue random (instr_done held low: R9)
    @(negedge clk); idle_in(); ei_set = 1; mi = 1;
    mf = mf; // no flag change this cycle
    for (int n = 0; n < 600; n++) rnd_cycle();
    chk("R9 no entry without done", 32'(save_valid | push_valid | pc_load_valid), 0);

    // directed entry: clock timer bit 13 and stopwatch bit 17 enabled, no watchdog
    clear_all();
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = 19'h22000; mm = 19'h22000;
    @(negedge clk); reg_wr = 0; src_pulse = 19'h22000;
    @(negedge clk); src_pulse = '0; #1;
    chk("R7 clock over stopwatch", 32'(irq_vector), 32'h010C);
    chk("R6 req", 32'(irq_req), 1);
    @(negedge clk); instr_done = 1; cur_pc = 16'h1234; cur_flags = 4'hA;
    @(negedge clk); instr_done = 0; cur_pc = 16'h5555; cur_flags = 4'h3; #1;
    chk("R10 save step", 32'(save_valid), 1);
    chk("R10 save data", 32'(save_data), 32'hA);
    chk("R10 no push yet", 32'(push_valid), 0);
    chk("R6 no req while busy", 32'(irq_req), 0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); #1;
      chk("R11 push held", 32'(push_valid), 1);
      chk("R11 push data", 32'(push_data), 32'h1234);
      chk("R10 I cleared", 32'(i_flag), 0);
      chk("R10 no load yet", 32'(pc_load_valid), 0);
    end
    push_ready = 1;
    @(negedge clk); push_ready = 0; #1;
    chk("R10 load", 32'(pc_load_valid), 1);
    chk("R10 ack", 32'(entry_ack), 1);
    chk("R8 load addr", 32'(pc_load_addr), 32'h010C);
    @(negedge clk); #1;
    chk("R12 no req with I clear", 32'(irq_req), 0);
    chk("R10 ack one cycle", 32'(entry_ack), 0);

    // watchdog unmaskable and top priority, masks cleared
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = '0;
    @(negedge clk); reg_wr = 0; wdt_pulse = 1; ei_set = 1;
    @(negedge clk); wdt_pulse = 0; ei_set = 0; #1;
    chk("R5 wdt req", 32'(irq_req), 1);
    chk("R5 wdt vector", 32'(irq_vector), 32'h0100);
    @(negedge clk); instr_done = 1; cur_pc = 16'hBEEF;
    @(negedge clk); instr_done = 0; push_ready = 1;
    @(negedge clk); #1;
    chk("R11 push no stall", 32'(push_data), 32'hBEEF);
    @(negedge clk); #1;
    chk("R8 wdt load", 32'(pc_load_addr), 32'h0100);
    push_ready = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule